// File: doc/BRIEF.md
# Cascadable Reload Down-Counter Timer Bank

This block holds four 8-bit interval timers behind a small byte-addressed register port. Each timer has a mode register, a base register that holds the reload period, and a read-only counter. A running timer counts down once for every cycle in which the I/O tick input is high. When its period has elapsed it raises its underflow output for one cycle and reloads from the base value.

An odd-numbered timer can be placed in cascade mode. When the even timer below it is then started, the two act as one 16-bit timer. The upper timer's base supplies the high byte of the period and the lower timer's base supplies the low byte. In that arrangement the lower timer owns the underflow output.

Software reaches the registers with 1-, 2- or 4-byte accesses. A multi-byte access packs several timers into one word. Any access the rules forbid is discarded and sets a sticky error flag. Only reset clears that flag.

Top module: `tmr_bank`

## Requirements
- R1: After reset, every mode, base and counter register reads zero, every underflow output is low and the error flag is low.
- R2: Mode registers sit at offsets 0x00–0x03, base registers at 0x10–0x13 and counters at 0x20–0x23, with the timer index in the low two address bits. Any other offset sets the error flag. A write to such an offset changes nothing, and a read from it returns zero.
- R3: The size code is 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes. A 2-byte access needs an even index and carries timer n in bits 15:8 and timer n+1 in bits 7:0. A 4-byte access needs index 0 and carries timer 0 in bits 31:24 down to timer 3 in bits 7:0. Size code 3, a misaligned access and any multi-byte mode write set the error flag and are discarded.
- R4: In a mode byte, bit 7 is count enable, bit 6 is load and bits 1:0 select the clock. Code 11 selects the cascade; every other code selects the I/O tick. A mode byte with bits 7 and 6 both set, or with any of bits 5:2 set, is discarded and sets the error flag.
- R5: Cascade select written to an even-numbered timer is discarded and sets the error flag.
- R6: While a timer is stopped, a base write also loads its counter, so a counter read returns the base value.
- R7: A legal mode write with count enable loads the counter from the base. The counter then drops by one on each later cycle with the I/O tick high, and reads show the ticks remaining.
- R8: On the tick that finds the counter at 1, the underflow output is high for the next cycle and the counter reloads from the base. A base write made while the timer runs takes effect only at that reload.
- R9: With a base period of zero, count enable does not start the timer.
- R10: A legal mode write with count enable clear stops the timer at once. The counter returns to the base value, and an underflow that would have fallen on that cycle does not occur.
- R11: Starting an even timer whose odd neighbour holds cascade select with count enable gives a 16-bit period of {upper base, lower base}. The two counters read as the low and high bytes of the remaining ticks, and only the even timer's underflow pulses.
- R12: Starting an even timer whose neighbour holds cascade select without count enable sets the error flag, and the even timer does not start.
- R13: Writes to a counter address set the error flag and change nothing. A mode write to the upper timer of a running pair is also rejected this way.
- R14: Once set, the error flag stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| io_tick | input | 1 | Prescaled count enable; one count per high cycle |
| bus_en | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data, combinational, right-aligned |
| uflow | output | 4 | One-cycle underflow pulse per timer |
| err_flag | output | 1 | Sticky access error |

## Verification
Assertions check several properties on every cycle:
- a stopped counter always equals its base;
- a running counter is never zero;
- an even timer never holds cascade select;
- the upper timer of a pair never pulses;
- a stop write silences underflow on the next cycle;
- the error flag never falls and follows every counter write.

Some behaviour needs the bench's directed scenarios, which compare exact cycle positions against values the bench works out itself:
- the byte packing of wide accesses;
- the 16-bit period of a pair;
- a base write being deferred to the next reload;
- the exact cycle of each underflow.

// File: rtl/tmr_pkg.sv
// Shared definitions for the timer bank: byte width, mode-byte fields,
// clock-select codes and the register groups the address decoder yields.
package tmr_pkg;
    localparam int BYTE_W = 8;
    localparam int MB_CE  = 7;      // count enable bit of a mode byte
    localparam int MB_LD  = 6;      // load request bit of a mode byte
    localparam logic [1:0] CLK_CASC = 2'b11;

    typedef enum logic [1:0] {
        RG_MODE = 2'd0,
        RG_BASE = 2'd1,
        RG_CNT  = 2'd2,
        RG_NONE = 2'd3
    } reg_grp_e;
endpackage

// File: rtl/tmr_bus_decode.sv
// Address and size decoder for the timer bank.
// Turns offset and size code into a register group, a mask of the timers the
// access touches, and the byte lane each touched timer uses.
// Assumes a power-of-two NUM_TMR of at most 8, so the index fits below bit 4.
module tmr_bus_decode
    import tmr_pkg::*;
#(
    parameter int NUM_TMR = 4,
    parameter int ADDR_W  = 8,
    localparam int IDX_W  = $clog2(NUM_TMR)
) (
    input  logic [ADDR_W-1:0]             addr,
    input  logic [1:0]                    size,
    output reg_grp_e                      grp,
    output logic [NUM_TMR-1:0]            sel,
    output logic [NUM_TMR-1:0][IDX_W-1:0] lane,
    output logic                          bad
);
    logic [IDX_W-1:0]    idx;
    logic [ADDR_W-5:0]   hi;
    logic [3-IDX_W:0]    mid;
    int                  nbytes;
    logic                size_ok;

    assign idx = addr[IDX_W-1:0];
    assign hi  = addr[ADDR_W-1:4];
    assign mid = addr[3:IDX_W];

    // Register group from the upper address nibble.
    always_comb begin
        unique case (hi)
            '0:                   grp = RG_MODE;
            (ADDR_W-4)'(1):       grp = RG_BASE;
            (ADDR_W-4)'(2):       grp = RG_CNT;
            default:              grp = RG_NONE;
        endcase
    end

    // Width, alignment and overall legality of the access.
    always_comb begin
        unique case (size)
            2'd0:    nbytes = 1;
            2'd1:    nbytes = 2;
            2'd2:    nbytes = 4;
            default: nbytes = 0;
        endcase
        size_ok = (nbytes != 0) && (nbytes <= NUM_TMR) &&
                  ((int'(idx) & (nbytes - 1)) == 0);
        bad = (grp == RG_NONE) || (mid != '0) || !size_ok;
    end

    // Per-timer select and byte lane; the lowest index takes the highest lane.
    always_comb begin
        for (int t = 0; t < NUM_TMR; t++) begin
            sel[t]  = !bad && (t >= int'(idx)) && (t < int'(idx) + nbytes);
            lane[t] = IDX_W'(int'(idx) + nbytes - 1 - t);
        end
    end
endmodule

// File: rtl/tmr_pair.sv
// One even/odd pair of 8-bit reload down-counters.
// The even (lower) timer may join the odd (upper) one into a 16-bit counter
// when the upper holds cascade select with count enable at the lower's start.
// Assumes that at most one mode byte of the pair is written per cycle, which
// the bank guarantees by allowing 1-byte mode writes only.
module tmr_pair
    import tmr_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   io_tick,
    input  logic [1:0]             mode_we,
    input  logic [1:0]             base_we,
    input  logic [1:0][BYTE_W-1:0] wbyte,
    output logic [1:0][BYTE_W-1:0] mode_q,
    output logic [1:0][BYTE_W-1:0] base_q,
    output logic [1:0][BYTE_W-1:0] cnt_q,
    output logic [1:0]             uflow,
    output logic                   wr_err
);
    logic [1:0][BYTE_W-1:0] mode_r, base_r, cnt_r;
    logic [1:0][BYTE_W-1:0] mode_nx, base_nx, cnt_nx;
    logic [1:0]             run_r, run_nx, uf_r, uf_nx;
    logic                   join_r, join_nx;
    logic                   up_casc, up_armed, lo_bad, up_bad, lo_period_nz;
    logic                   tick_lo, tick_up;
    logic [2*BYTE_W-1:0]    pair_cnt, pair_base;

    assign pair_cnt  = cnt_r;
    assign pair_base = base_r;
    assign up_casc   = (mode_r[1][1:0] == CLK_CASC);
    assign up_armed  = up_casc && mode_r[1][MB_CE];
    assign tick_lo   = io_tick && run_r[0];
    assign tick_up   = io_tick && run_r[1];

    // Legality of the mode byte offered to each timer.
    always_comb begin
        lo_bad = mode_we[0] && ((wbyte[0][MB_CE] && wbyte[0][MB_LD]) ||
                                (wbyte[0][5:2] != '0) ||
                                (wbyte[0][1:0] == CLK_CASC) ||
                                (wbyte[0][MB_CE] && up_casc && !mode_r[1][MB_CE]));
        up_bad = mode_we[1] && ((wbyte[1][MB_CE] && wbyte[1][MB_LD]) ||
                                (wbyte[1][5:2] != '0) || join_r);
        lo_period_nz = up_armed ? (pair_base != '0) : (base_r[0] != '0);
    end

    // Next state: counting first, then mode writes, then base writes override.
    always_comb begin
        mode_nx = mode_r;
        base_nx = base_r;
        cnt_nx  = cnt_r;
        run_nx  = run_r;
        join_nx = join_r;
        uf_nx   = '0;

        if (tick_lo) begin
            if (join_r) begin
                if (pair_cnt == 16'd1) begin
                    uf_nx[0] = 1'b1;
                    cnt_nx   = pair_base;
                    if (pair_base == '0) begin
                        run_nx[0] = 1'b0;
                        join_nx   = 1'b0;
                    end
                end else begin
                    cnt_nx = pair_cnt - 16'd1;
                end
            end else if (cnt_r[0] == 8'd1) begin
                uf_nx[0]  = 1'b1;
                cnt_nx[0] = base_r[0];
                if (base_r[0] == '0) run_nx[0] = 1'b0;
            end else begin
                cnt_nx[0] = cnt_r[0] - 8'd1;
            end
        end

        if (tick_up) begin
            if (cnt_r[1] == 8'd1) begin
                uf_nx[1]  = 1'b1;
                cnt_nx[1] = base_r[1];
                if (base_r[1] == '0) run_nx[1] = 1'b0;
            end else begin
                cnt_nx[1] = cnt_r[1] - 8'd1;
            end
        end

        if (mode_we[0] && !lo_bad) begin
            mode_nx[0] = wbyte[0];
            uf_nx[0]   = 1'b0;
            cnt_nx[0]  = base_r[0];
            if (join_r) cnt_nx[1] = base_r[1];
            if (wbyte[0][MB_CE] && lo_period_nz) begin
                run_nx[0] = 1'b1;
                join_nx   = up_armed;
                if (up_armed) cnt_nx[1] = base_r[1];
            end else begin
                run_nx[0] = 1'b0;
                join_nx   = 1'b0;
            end
        end

        if (mode_we[1] && !up_bad) begin
            mode_nx[1] = wbyte[1];
            uf_nx[1]   = 1'b0;
            cnt_nx[1]  = base_r[1];
            run_nx[1]  = wbyte[1][MB_CE] && (wbyte[1][1:0] != CLK_CASC) &&
                         (base_r[1] != '0);
        end

        for (int k = 0; k < 2; k++) begin
            if (base_we[k]) base_nx[k] = wbyte[k];
        end
        if (base_we[0] && !run_nx[0])             cnt_nx[0] = wbyte[0];
        if (base_we[1] && !run_nx[1] && !join_nx) cnt_nx[1] = wbyte[1];
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_r <= '0;
            base_r <= '0;
            cnt_r  <= '0;
            run_r  <= '0;
            join_r <= 1'b0;
            uf_r   <= '0;
        end else begin
            mode_r <= mode_nx;
            base_r <= base_nx;
            cnt_r  <= cnt_nx;
            run_r  <= run_nx;
            join_r <= join_nx;
            uf_r   <= uf_nx;
        end
    end

    assign mode_q = mode_r;
    assign base_q = base_r;
    assign cnt_q  = cnt_r;
    assign uflow  = uf_r;
    assign wr_err = lo_bad || up_bad;

    // R6
    stopped_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_r[0] |-> cnt_r[0] == base_r[0]);
    // R6
    stopped_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(run_r[1] || join_r) |-> cnt_r[1] == base_r[1]);
    // R9
    nonzero_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_r[0] |-> (join_r ? (pair_cnt != '0) : (cnt_r[0] != '0)));
    // R5
    even_no_casc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_r[0][1:0] != CLK_CASC);
    // R11
    upper_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        join_r |-> !uflow[1]);
    // R10
    stop_silences_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we[0] && !wbyte[0][MB_CE] && wbyte[0][5:2] == '0 &&
         wbyte[0][1:0] != CLK_CASC) |=> !uflow[0]);
    // R8
    uflow_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uflow[0] |-> $past(io_tick));
endmodule

// File: rtl/tmr_bank.sv
// Bank of NUM_TMR 8-bit reload down-counters behind a byte-addressed port.
// Decodes accesses, enforces the size and alignment rules, routes byte lanes
// to the timer pairs, muxes read data and keeps a sticky error flag.
// Assumes NUM_TMR is even and at most 8; reads are combinational.
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int NUM_TMR = 4,
    parameter int ADDR_W  = 8,
    localparam int DATA_W = NUM_TMR * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_tick,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_TMR-1:0] uflow,
    output logic              err_flag
);
    localparam int IDX_W    = $clog2(NUM_TMR);
    localparam int NUM_PAIR = NUM_TMR / 2;

    reg_grp_e                          grp;
    logic [NUM_TMR-1:0]                sel;
    logic [NUM_TMR-1:0][IDX_W-1:0]     lane;
    logic                              dec_bad, acc_err, acc_ok;
    logic [NUM_TMR-1:0][BYTE_W-1:0]    wbyte, mode_q, base_q, cnt_q;
    logic [NUM_TMR-1:0]                mode_we, base_we;
    logic [NUM_PAIR-1:0]               pair_err;

    tmr_bus_decode #(.NUM_TMR(NUM_TMR), .ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .size (bus_size),
        .grp  (grp),
        .sel  (sel),
        .lane (lane),
        .bad  (dec_bad)
    );

    // Access-level rule check: decode, counter writes, wide mode writes.
    always_comb begin
        acc_err = bus_en && (dec_bad ||
                             (bus_wr && grp == RG_CNT) ||
                             (bus_wr && grp == RG_MODE && bus_size != 2'd0));
        acc_ok  = bus_en && !acc_err;
    end

    // Per-timer write strobes and byte lanes.
    always_comb begin
        for (int t = 0; t < NUM_TMR; t++) begin
            wbyte[t]   = bus_wdata[{lane[t], 3'b000} +: BYTE_W];
            mode_we[t] = acc_ok && bus_wr && grp == RG_MODE && sel[t];
            base_we[t] = acc_ok && bus_wr && grp == RG_BASE && sel[t];
        end
    end

    for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
        tmr_pair u_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .io_tick (io_tick),
            .mode_we (mode_we[2*p+1 -: 2]),
            .base_we (base_we[2*p+1 -: 2]),
            .wbyte   (wbyte[2*p+1 -: 2]),
            .mode_q  (mode_q[2*p+1 -: 2]),
            .base_q  (base_q[2*p+1 -: 2]),
            .cnt_q   (cnt_q[2*p+1 -: 2]),
            .uflow   (uflow[2*p+1 -: 2]),
            .wr_err  (pair_err[p])
        );
    end

    // Read data: each selected timer's byte placed in its lane.
    always_comb begin
        bus_rdata = '0;
        if (acc_ok && !bus_wr) begin
            for (int t = 0; t < NUM_TMR; t++) begin
                if (sel[t]) begin
                    unique case (grp)
                        RG_MODE: bus_rdata |= DATA_W'(mode_q[t]) << {lane[t], 3'b000};
                        RG_BASE: bus_rdata |= DATA_W'(base_q[t]) << {lane[t], 3'b000};
                        default: bus_rdata |= DATA_W'(cnt_q[t])  << {lane[t], 3'b000};
                    endcase
                end
            end
        end
    end

    // Sticky error flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                     err_flag <= 1'b0;
        else if (acc_err || |pair_err)  err_flag <= 1'b1;
    end

    // R14
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);
    // R13
    cnt_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_wr && bus_addr[ADDR_W-1:4] == (ADDR_W-4)'(2)) |=> err_flag);
endmodule

// File: tb/tb_tmr_bank.sv
// Directed bench for tmr_bank: one task per scenario, each checking itself.
module tb_tmr_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_tick = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  uflow;
    logic        err_flag;
    int          total = 0;
    int          bad = 0;

    always #5 clk = ~clk;

    tmr_bank dut (
        .clk(clk), .rst_n(rst_n), .io_tick(io_tick), .bus_en(bus_en),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .uflow(uflow),
        .err_flag(err_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        io_tick = 1'b0;
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
    endtask

    // Write: driven after a negedge, applied on the next posedge.
    task automatic wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    // Read: combinational, sampled inside the low phase, no clock edge.
    task automatic rd(input logic [7:0] a, input logic [1:0] sz, output logic [31:0] q);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_size = sz;
        #1;
        q = bus_rdata;
        bus_en = 1'b0;
    endtask

    // Read held across one clock edge so an illegal read can register its error.
    task automatic rd_hold(input logic [7:0] a, input logic [1:0] sz, output logic [31:0] q);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_size = sz;
        #1;
        q = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] q;
        do_reset();
        rd(8'h00, 2'd2, q); chk("R1 modes", q, 0);
        rd(8'h10, 2'd2, q); chk("R1 bases", q, 0);
        rd(8'h20, 2'd2, q); chk("R1 counters", q, 0);
        chk("R1 uflow", {28'b0, uflow}, 0);
        chk("R1 err", {31'b0, err_flag}, 0);
    endtask

    task automatic t_decode();
        logic [31:0] q;
        do_reset();
        wr(8'h13, 2'd0, 32'h5C);
        rd(8'h13, 2'd0, q); chk("R2 base3 legal", q, 32'h5C);
        chk("R2 legal no err", {31'b0, err_flag}, 0);
        wr(8'h14, 2'd0, 32'h77);
        chk("R2 bad offset err", {31'b0, err_flag}, 1);
        rd(8'h10, 2'd2, q); chk("R2 bad write ignored", q, 32'h0000005C);
        do_reset();
        rd_hold(8'h35, 2'd0, q); chk("R2 bad read data", q, 0);
        chk("R2 bad read err", {31'b0, err_flag}, 1);
    endtask

    task automatic t_pack();
        logic [31:0] q;
        do_reset();
        wr(8'h10, 2'd2, 32'h11223344);
        rd(8'h12, 2'd1, q); chk("R3 2B at 2", q, 32'h3344);
        rd(8'h11, 2'd0, q); chk("R3 1B at 1", q, 32'h22);
        rd(8'h10, 2'd1, q); chk("R3 2B at 0", q, 32'h1122);
        chk("R3 legal no err", {31'b0, err_flag}, 0);
        wr(8'h11, 2'd1, 32'hAAAA);
        chk("R3 misaligned err", {31'b0, err_flag}, 1);
        wr(8'h12, 2'd2, 32'hBBBBBBBB);
        wr(8'h10, 2'd3, 32'hCCCCCCCC);
        rd(8'h10, 2'd2, q); chk("R3 bad writes ignored", q, 32'h11223344);
        wr(8'h00, 2'd1, 32'h8080);
        rd(8'h00, 2'd2, q); chk("R3 wide mode write ignored", q, 0);
    endtask

    task automatic t_mode_bits();
        logic [31:0] q;
        do_reset();
        wr(8'h01, 2'd0, 32'hC0);
        chk("R4 CE+LD err", {31'b0, err_flag}, 1);
        rd(8'h01, 2'd0, q); chk("R4 CE+LD discarded", q, 0);
        wr(8'h01, 2'd0, 32'h04);
        rd(8'h01, 2'd0, q); chk("R4 reserved bits discarded", q, 0);
        do_reset();
        wr(8'h01, 2'd0, 32'h41);
        rd(8'h01, 2'd0, q); chk("R4 legal mode stored", q, 32'h41);
        chk("R4 legal no err", {31'b0, err_flag}, 0);
        wr(8'h11, 2'd0, 32'h03);
        wr(8'h01, 2'd0, 32'h81);
        io_tick = 1'b1;
        idle(1);
        rd(8'h21, 2'd0, q); chk("R4 sel 01 counts on tick", q, 2);
        idle(2);
        chk("R4 sel 01 underflow", {31'b0, uflow[1]}, 1);
        io_tick = 1'b0;
    endtask

    task automatic t_casc_even();
        logic [31:0] q;
        do_reset();
        wr(8'h02, 2'd0, 32'h83);
        chk("R5 even cascade err", {31'b0, err_flag}, 1);
        rd(8'h02, 2'd0, q); chk("R5 even cascade discarded", q, 0);
        wr(8'h00, 2'd0, 32'h03);
        rd(8'h00, 2'd0, q); chk("R5 timer0 cascade discarded", q, 0);
    endtask

    task automatic t_stopped_base();
        logic [31:0] q;
        do_reset();
        io_tick = 1'b1;
        wr(8'h11, 2'd0, 32'h5A);
        idle(3);
        rd(8'h21, 2'd0, q); chk("R6 stopped counter = base", q, 32'h5A);
        io_tick = 1'b0;
    endtask

    task automatic t_count();
        logic [31:0] q;
        do_reset();
        wr(8'h10, 2'd0, 32'd5);
        wr(8'h00, 2'd0, 32'h80);
        rd(8'h20, 2'd0, q); chk("R7 loaded at start", q, 5);
        idle(2);
        rd(8'h20, 2'd0, q); chk("R7 no tick no count", q, 5);
        io_tick = 1'b1;
        idle(2);
        rd(8'h20, 2'd0, q); chk("R7 remaining after 2 ticks", q, 3);
        idle(2);
        rd(8'h20, 2'd0, q); chk("R7 remaining 1", q, 1);
        chk("R8 no early uflow", {31'b0, uflow[0]}, 0);
        wr(8'h10, 2'd0, 32'd9);
        chk("R8 underflow pulse", {31'b0, uflow[0]}, 1);
        rd(8'h20, 2'd0, q); chk("R8 reload uses old base", q, 5);
        rd(8'h10, 2'd0, q); chk("R8 base updated", q, 9);
        idle(1);
        chk("R8 pulse one cycle", {31'b0, uflow[0]}, 0);
        rd(8'h20, 2'd0, q); chk("R8 counting on", q, 4);
        idle(4);
        chk("R8 second underflow", {31'b0, uflow[0]}, 1);
        rd(8'h20, 2'd0, q); chk("R8 reload new base", q, 9);
        io_tick = 1'b0;
    endtask

    task automatic t_zero_base();
        logic [31:0] q;
        int          seen = 0;
        do_reset();
        wr(8'h00, 2'd0, 32'h80);
        io_tick = 1'b1;
        for (int i = 0; i < 5; i++) begin
            idle(1);
            if (uflow[0]) seen++;
        end
        chk("R9 zero base no uflow", seen, 0);
        wr(8'h10, 2'd0, 32'd3);
        idle(3);
        rd(8'h20, 2'd0, q); chk("R9 zero base not running", q, 3);
        io_tick = 1'b0;
    endtask

    task automatic t_stop();
        logic [31:0] q;
        int          seen = 0;
        do_reset();
        wr(8'h12, 2'd0, 32'd2);
        wr(8'h02, 2'd0, 32'h80);
        io_tick = 1'b1;
        idle(1);
        rd(8'h22, 2'd0, q); chk("R10 at 1 before stop", q, 1);
        wr(8'h02, 2'd0, 32'h00);
        chk("R10 pending uflow suppressed", {31'b0, uflow[2]}, 0);
        rd(8'h22, 2'd0, q); chk("R10 counter back to base", q, 2);
        for (int i = 0; i < 6; i++) begin
            idle(1);
            if (uflow[2]) seen++;
        end
        chk("R10 stays stopped", seen, 0);
        io_tick = 1'b0;
    endtask

    task automatic t_pair();
        logic [31:0] q;
        int          up_seen = 0;
        int          lo_seen = 0;
        do_reset();
        wr(8'h10, 2'd1, 32'h0201);
        wr(8'h01, 2'd0, 32'h83);
        chk("R11 cascade arm no err", {31'b0, err_flag}, 0);
        wr(8'h00, 2'd0, 32'h80);
        rd(8'h20, 2'd1, q); chk("R11 loaded 16-bit", q, 32'h0201);
        io_tick = 1'b1;
        idle(3);
        rd(8'h20, 2'd1, q); chk("R11 borrow into high byte", q, 32'hFF00);
        for (int i = 0; i < 254; i++) begin
            idle(1);
            if (uflow[1]) up_seen++;
            if (uflow[0]) lo_seen++;
        end
        chk("R11 no early uflow", lo_seen, 0);
        rd(8'h20, 2'd1, q); chk("R11 remaining 1", q, 32'h0100);
        idle(1);
        chk("R11 pair underflow", {31'b0, uflow[0]}, 1);
        if (uflow[1]) up_seen++;
        chk("R11 upper never pulses", up_seen, 0);
        rd(8'h20, 2'd1, q); chk("R11 pair reload", q, 32'h0201);
        wr(8'h01, 2'd0, 32'h00);
        chk("R13 upper of pair err", {31'b0, err_flag}, 1);
        rd(8'h20, 2'd1, q); chk("R13 pair keeps running", q, 32'h0101);
        rd(8'h01, 2'd0, q); chk("R13 upper mode kept", q, 32'h83);
        io_tick = 1'b0;
    endtask

    task automatic t_pair_err();
        logic [31:0] q;
        do_reset();
        wr(8'h10, 2'd1, 32'h0501);
        wr(8'h01, 2'd0, 32'h03);
        chk("R12 cascade without CE legal", {31'b0, err_flag}, 0);
        wr(8'h00, 2'd0, 32'h80);
        chk("R12 start err", {31'b0, err_flag}, 1);
        io_tick = 1'b1;
        idle(4);
        rd(8'h20, 2'd0, q); chk("R12 lower not started", q, 5);
        rd(8'h00, 2'd0, q); chk("R12 mode discarded", q, 0);
        io_tick = 1'b0;
    endtask

    task automatic t_cnt_write();
        logic [31:0] q;
        do_reset();
        wr(8'h20, 2'd0, 32'h12);
        chk("R13 counter write err", {31'b0, err_flag}, 1);
        rd(8'h20, 2'd0, q); chk("R13 counter unchanged", q, 0);
        rd(8'h10, 2'd0, q); chk("R13 base unchanged", q, 0);
        idle(5);
        chk("R14 err sticky", {31'b0, err_flag}, 1);
        do_reset();
        chk("R14 reset clears err", {31'b0, err_flag}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        t_reset();
        t_decode();
        t_pack();
        t_mode_bits();
        t_casc_even();
        t_stopped_base();
        t_count();
        t_zero_base();
        t_stop();
        t_pair();
        t_pair_err();
        t_cnt_write();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule